// File: doc/BRIEF.md
# Packed SIMD Shift, Rotate and Shuffle Unit

This unit takes a 64-bit packed operand and moves its bits inside lanes. Four shift kinds are offered: logical left, logical right, arithmetic right and rotate right. Each one works within 16-bit lanes, within 32-bit lanes or over the full 64-bit value, and no bit ever crosses from one lane into the next. Two permutations sit beside the shifts. The first is a halfword shuffle steered by an 8-bit control. The second is a byte-offset extract taken from the 128-bit concatenation of two operands.

Every result comes with a 32-bit flag word holding a sign (N) bit and a zero (Z) bit for each lane. Operations enter on a valid/ready input stream and leave through a single registered output stage that also speaks valid/ready. An operation is accepted on a rising edge when both `in_valid` and `in_ready` are high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. When `out_ready` is low, the output holds its result, and `in_ready` stays low, for as long as the stall lasts.

Top module: `pkt_shift_unit`

## Requirements
- R1: For logical shifts (in_kind 0 = left, 1 = right) each lane is shifted separately, and bits never move into a neighbouring lane. A count at or above the lane width gives a zero lane. in_size 0 selects 16-bit lanes, 1 selects 32-bit lanes and 2 selects the whole 64-bit value.
- R2: Arithmetic right shift (in_kind 2) fills the vacated bits of each lane with that lane's own top bit. A count at or above the lane width fills the whole lane with the sign bit.
- R3: Rotate right (in_kind 3) turns each lane by the count modulo the lane width, so lane = (lane >> r) | (lane << (W − r)), with r = count mod W.
- R4: With in_size 2, every shift kind acts on the whole 64-bit operand as one lane.
- R5: Shuffle (in_mode 1): result halfword k is operand halfword in_cnt[2k+1:2k], for k = 0..3.
- R6: Align (in_mode 2): with n = in_cnt[2:0], the result is (a >> 8n) | (b << (64 − 8n)). An offset of 0 returns a unchanged, and in_cnt[7:3] is ignored.
- R7: Flag layout. For 16-bit lanes and for shuffle, lane i places N at bit 8i+7 and Z at bit 8i+6. For 32-bit lanes, lane i places N at bit 16i+15 and Z at bit 16i+14. For 64-bit results, align and pass-through, N is at bit 31 and Z is at bit 30. N is the lane's top bit, Z is set when the lane is all zero, and every other flag bit is 0.
- R8: in_size 3 in shift mode, and in_mode 3, both return operand a unchanged, with flags in the 64-bit layout.
- R9: While out_valid is high and out_ready is low, out_data and out_flags stay constant and in_ready is low.
- R10: After reset, out_valid is low and in_ready is high.
- R11: An operation accepted on a clock edge appears with out_valid high right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can take an operation this cycle |
| in_mode | input | 2 | 0 shift/rotate, 1 shuffle, 2 align, 3 pass-through |
| in_kind | input | 2 | 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right |
| in_size | input | 2 | 0 16-bit lanes, 1 32-bit lanes, 2 64-bit, 3 pass-through |
| in_cnt | input | 8 | Shift count, shuffle control or byte offset |
| in_a | input | 64 | Main operand |
| in_b | input | 64 | Upper operand for align |
| out_valid | output | 1 | A result is held |
| out_ready | input | 1 | The consumer takes the result |
| out_data | output | 64 | Result |
| out_flags | output | 32 | Per-lane N/Z flags |

## Verification
Random operands are combined with counts taken from the whole 0–255 range. This catches results that wrongly use the count modulo the lane width when it should saturate, and the reverse. Directed cases use lanes whose top bit is set, so a sign leaking from one lane into the next shows up. Other directed cases use counts exactly equal to the lane width and one below it, which tell lane-confined shifting apart from a whole-vector shift. The shuffle is tried with a reversal pattern and with a broadcast pattern. Align is tried at offsets 0 and 7 with high control bits set. A stalled consumer, together with a second offered operation, separates a correctly held output from one that is overwritten.

// File: rtl/pkt_shift_pkg.sv
package pkt_shift_pkg;
  localparam int DATA_W = 64;
  localparam int CNT_W  = 8;
  localparam int FLAG_W = DATA_W / 2;
  localparam int HALF_W = 16;

  typedef enum logic [1:0] {MD_SHIFT = 2'd0, MD_SHUF = 2'd1, MD_ALIGN = 2'd2, MD_PASS = 2'd3} mode_e;
  typedef enum logic [1:0] {SK_LSL = 2'd0, SK_LSR = 2'd1, SK_ASR = 2'd2, SK_ROR = 2'd3} kind_e;
  typedef enum logic [1:0] {LY_HALF = 2'd0, LY_WORD = 2'd1, LY_DWORD = 2'd2, LY_PASS = 2'd3} layout_e;
endpackage

// File: rtl/pkt_lane_shift.sv
module pkt_lane_shift
  import pkt_shift_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 8
) (
  input  logic [W-1:0]  data,
  input  logic [CW-1:0] cnt,
  input  logic [1:0]    kind,
  output logic [W-1:0]  res
);
  localparam int SW = $clog2(W);

  logic          over;
  logic [SW-1:0] rot;
  logic [2*W-1:0] dbl;

  assign over = (cnt >= CW'(W));
  assign rot  = cnt[SW-1:0];
  assign dbl  = {data, data} >> rot;

  always_comb begin
    unique case (kind)
      SK_LSL:  res = over ? '0 : (data << cnt);
      SK_LSR:  res = over ? '0 : (data >> cnt);
      SK_ASR:  res = over ? {W{data[W-1]}} : W'($signed(data) >>> cnt);
      default: res = dbl[W-1:0];
    endcase
  end
endmodule

// File: rtl/pkt_permute.sv
module pkt_permute
  import pkt_shift_pkg::*;
(
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [CNT_W-1:0]  ctl,
  output logic [DATA_W-1:0] shuf,
  output logic [DATA_W-1:0] aligned
);
  localparam int NH = DATA_W / HALF_W;

  for (genvar k = 0; k < NH; k++) begin : g_sel
    logic [1:0] src;
    assign src = ctl[2*k +: 2];
    assign shuf[HALF_W*k +: HALF_W] = a[HALF_W*src +: HALF_W];
  end

  logic [2*DATA_W-1:0] cat;
  assign cat     = {b, a} >> {ctl[2:0], 3'b000};
  assign aligned = cat[DATA_W-1:0];
endmodule

// File: rtl/pkt_flag_gen.sv
module pkt_flag_gen
  import pkt_shift_pkg::*;
(
  input  logic [DATA_W-1:0] res,
  input  logic [1:0]        layout,
  output logic [FLAG_W-1:0] flags
);
  always_comb begin
    flags = '0;
    unique case (layout)
      LY_HALF:
        for (int i = 0; i < DATA_W / 16; i++) begin
          flags[8*i+7] = res[16*i+15];
          flags[8*i+6] = (res[16*i +: 16] == '0);
        end
      LY_WORD:
        for (int i = 0; i < DATA_W / 32; i++) begin
          flags[16*i+15] = res[32*i+31];
          flags[16*i+14] = (res[32*i +: 32] == '0);
        end
      default: begin
        flags[FLAG_W-1] = res[DATA_W-1];
        flags[FLAG_W-2] = (res == '0);
      end
    endcase
  end
endmodule

// File: rtl/pkt_shift_unit.sv
module pkt_shift_unit
  import pkt_shift_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_mode,
  input  logic [1:0]        in_kind,
  input  logic [1:0]        in_size,
  input  logic [CNT_W-1:0]  in_cnt,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [FLAG_W-1:0] out_flags
);
  localparam int NSIZE = 3;

  logic [NSIZE-1:0][DATA_W-1:0] bank_res;
  logic [DATA_W-1:0] shuf, aligned, res;
  logic [1:0]        layout;
  logic [FLAG_W-1:0] flags;
  logic              take;

  for (genvar s = 0; s < NSIZE; s++) begin : g_size
    localparam int LW = HALF_W << s;
    for (genvar l = 0; l < DATA_W / LW; l++) begin : g_lane
      pkt_lane_shift #(.W(LW), .CW(CNT_W)) u_lane (
        .data (in_a[LW*l +: LW]),
        .cnt  (in_cnt),
        .kind (in_kind),
        .res  (bank_res[s][LW*l +: LW])
      );
    end
  end

  pkt_permute u_perm (
    .a       (in_a),
    .b       (in_b),
    .ctl     (in_cnt),
    .shuf    (shuf),
    .aligned (aligned)
  );

  always_comb begin
    unique case (in_mode)
      MD_SHIFT: begin
        if (in_size == LY_PASS) begin
          res    = in_a;
          layout = LY_DWORD;
        end else begin
          res    = bank_res[in_size];
          layout = in_size;
        end
      end
      MD_SHUF:  begin res = shuf;    layout = LY_HALF;  end
      MD_ALIGN: begin res = aligned; layout = LY_DWORD; end
      default:  begin res = in_a;    layout = LY_DWORD; end
    endcase
  end

  pkt_flag_gen u_flags (
    .res    (res),
    .layout (layout),
    .flags  (flags)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_flags <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= res;
        out_flags <= flags;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pkt_shift_chk.sv
module pkt_shift_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_data,
  input logic [31:0] out_flags
);
  // R9
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_flags));

  // R11
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R7
  top_sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_flags[31] == out_data[63]);

  // R7
  unused_flag_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags & ~32'hC0C0_C0C0) == 32'h0);

  // R7
  zero_has_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_data == 64'h0 |-> (out_flags & 32'h4040_4040) != 32'h0);

  // R10
  reset_empty_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> !out_valid);
endmodule

bind pkt_shift_unit pkt_shift_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_flags (out_flags)
);

// File: tb/test_pkt_shift_unit.sv
`timescale 1ns/1ps
module test_pkt_shift_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_mode = '0, in_kind = '0, in_size = '0;
  logic [7:0]  in_cnt = '0;
  logic [63:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic [31:0] out_flags;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pkt_shift_unit i_pkt_shift_unit (.*);

  task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [1:0] md, input logic [1:0] sz, input logic [1:0] kd,
                                input logic [7:0] c, input logic [63:0] a, input logic [63:0] b,
                                output logic [63:0] r, output logic [31:0] f);
    int lay, w, lw, n, cc;
    r = a; lay = 2; cc = int'(c);
    if (md == 2'd0 && sz != 2'd3) begin
      w = 16 << sz; lay = sz;
      for (int base = 0; base < 64; base += w)
        for (int j = 0; j < w; j++)
          case (kd)
            2'd0: r[base+j] = (j >= cc) ? a[base+j-cc] : 1'b0;
            2'd1: r[base+j] = (j + cc < w) ? a[base+j+cc] : 1'b0;
            2'd2: r[base+j] = (j + cc < w) ? a[base+j+cc] : a[base+w-1];
            default: r[base+j] = a[base + ((j + cc) % w)];
          endcase
    end else if (md == 2'd1) begin
      lay = 0;
      for (int k = 0; k < 4; k++) r[16*k +: 16] = a[16*int'(c[2*k +: 2]) +: 16];
    end else if (md == 2'd2) begin
      n = 8 * int'(c[2:0]);
      for (int j = 0; j < 64; j++) r[j] = (j + n < 64) ? a[j+n] : b[j+n-64];
    end
    f = '0; lw = 16 << lay;
    for (int i = 0; i < 64 / lw; i++) begin
      logic z;
      z = 1'b1;
      for (int j = 0; j < lw; j++) if (r[lw*i+j]) z = 1'b0;
      f[(lw/2)*i + lw/2 - 1] = r[lw*i + lw - 1];
      f[(lw/2)*i + lw/2 - 2] = z;
    end
  endfunction

  function automatic string tag_of(input logic [1:0] md, input logic [1:0] sz, input logic [1:0] kd);
    if (md == 2'd1) return "R5 R7";
    if (md == 2'd2) return "R6 R7";
    if (md == 2'd3 || sz == 2'd3) return "R8 R7";
    if (sz == 2'd2) return "R4 R7";
    if (kd == 2'd2) return "R2 R7";
    if (kd == 2'd3) return "R3 R7";
    return "R1 R7";
  endfunction

  task automatic run(input logic [1:0] md, input logic [1:0] sz, input logic [1:0] kd,
                     input logic [7:0] c, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] er; logic [31:0] ef;
    model(md, sz, kd, c, a, b, er, ef);
    @(negedge clk);
    in_mode = md; in_size = sz; in_kind = kd; in_cnt = c; in_a = a; in_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 out_valid", {95'd0, out_valid}, {95'd0, 1'b1});
    check(tag_of(md, sz, kd), {out_data, out_flags}, {er, ef});
  endtask

  initial begin
    logic [63:0] er1, er2; logic [31:0] ef1, ef2;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 idle", {94'd0, out_valid, in_ready}, {94'd0, 1'b0, 1'b1});

    // directed corner cases
    run(2'd0, 2'd0, 2'd0, 8'd16,  64'hFFFF_FFFF_FFFF_FFFF, 64'h0);    // R1 count = width
    run(2'd0, 2'd0, 2'd0, 8'd4,   64'h8001_F00F_0F0F_FFFF, 64'h0);    // R1 no leak left
    run(2'd0, 2'd1, 2'd1, 8'd31,  64'hFFFF_FFFF_8000_0000, 64'h0);    // R1 word right
    run(2'd0, 2'd0, 2'd2, 8'd15,  64'h8000_7FFF_8001_0001, 64'h0);    // R2 width-1
    run(2'd0, 2'd1, 2'd2, 8'd40,  64'h8000_0000_7FFF_FFFF, 64'h0);    // R2 over-range
    run(2'd0, 2'd0, 2'd3, 8'd17,  64'h1234_8001_0001_FFFE, 64'h0);    // R3 modulo
    run(2'd0, 2'd1, 2'd3, 8'd0,   64'hDEAD_BEEF_0000_0001, 64'h0);    // R3 zero count
    run(2'd0, 2'd2, 2'd3, 8'd68,  64'h0123_4567_89AB_CDEF, 64'h0);    // R4 rotate 64
    run(2'd0, 2'd2, 2'd2, 8'd200, 64'h8000_0000_0000_0000, 64'h0);    // R4 asr over
    run(2'd1, 2'd0, 2'd0, 8'h1B,  64'h4444_3333_2222_1111, 64'h0);    // R5 reverse
    run(2'd1, 2'd0, 2'd0, 8'hAA,  64'h0000_8000_0000_0000, 64'h0);    // R5 broadcast
    run(2'd2, 2'd0, 2'd0, 8'hF8,  64'h1122_3344_5566_7788, 64'hAAAA_BBBB_CCCC_DDDD); // R6 offset 0
    run(2'd2, 2'd0, 2'd0, 8'h07,  64'h1122_3344_5566_7788, 64'hAAAA_BBBB_CCCC_DDDD); // R6 offset 7
    run(2'd0, 2'd3, 2'd1, 8'd5,   64'h8000_0000_0000_0000, 64'h0);    // R8 size 3
    run(2'd3, 2'd1, 2'd0, 8'd9,   64'h0,                   64'h5);    // R8 mode 3

    // constrained random
    for (int t = 0; t < 400; t++) begin
      logic [7:0] c;
      c = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 70);
      run(2'($urandom), 2'($urandom), 2'($urandom), c,
          {$urandom, $urandom}, {$urandom, $urandom});
    end

    // R9 back-pressure: hold first result, refuse second op
    model(2'd0, 2'd0, 2'd1, 8'd3, 64'hF0F0_F0F0_F0F0_F0F0, 64'h0, er1, ef1);
    model(2'd1, 2'd0, 2'd0, 8'h00, 64'h0000_0000_0000_9999, 64'h0, er2, ef2);
    @(negedge clk);
    out_ready = 1'b0;
    in_mode = 2'd0; in_size = 2'd0; in_kind = 2'd1; in_cnt = 8'd3;
    in_a = 64'hF0F0_F0F0_F0F0_F0F0; in_valid = 1'b1;
    @(negedge clk);
    in_mode = 2'd1; in_cnt = 8'h00; in_a = 64'h0000_0000_0000_9999;
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      check("R9 in_ready low", {95'd0, in_ready}, {95'd0, 1'b0});
      check("R9 held", {out_data, out_flags}, {er1, ef1});
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 second op", {out_data, out_flags}, {er2, ef2});
    @(negedge clk);
    check("R9 drained", {95'd0, out_valid}, {95'd0, 1'b0});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule